// File: doc/BRIEF.md
# Product-Term Cluster Allocator with XOR

This block is the steering stage between the product-term array and the storage elements of one logic block of macrocells. Each macrocell owns a small cluster of product terms and one spare term. A static configuration word per macrocell sets four things: the cluster's mode (synchronous or asynchronous), where the cluster is delivered, whether the spare term joins the cluster or feeds the XOR gate, and the constant used as the XOR's second input. For every macrocell the block ORs together all clusters that land on it. It then passes the result through a two-input XOR to form that macrocell's D/T input.

The block is purely combinational. A cluster can go to its home macrocell, to a neighbour one or two positions away, or nowhere. Several clusters can gang onto one macrocell to build wide sums. Steering does not wrap around the ends of the block. A cluster whose configuration names more than one destination, or a destination outside the block, is reported and dropped. A macrocell that receives more clusters than the allowed join limit is also reported.

Top module: `ptc_allocator`

## Requirements
- R1: Product-term input layout: macrocell i owns bits [5i+4:5i] of `ptIn`, where bits 5i..5i+3 are its cluster terms and bit 5i+4 is its spare term. Configuration bit 8i+0 is the mode (0 = synchronous). In synchronous mode a cluster's value is the OR of all four of its cluster terms.
- R2: In asynchronous mode (bit 8i+0 = 1) only cluster terms 5i and 5i+1 contribute, and terms 5i+2 and 5i+3 have no effect on any output.
- R3: Cluster size follows the mode of the cluster's home macrocell, even when the cluster is delivered to another macrocell.
- R4: With bit 8i+1 = 0 the spare term is ORed into the cluster and travels with it to its destination. The XOR second input of macrocell i is then the polarity bit 8i+2.
- R5: With bit 8i+1 = 1 the spare term of macrocell i drives that macrocell's XOR second input, the polarity bit has no effect, and the spare term is not part of the cluster.
- R6: When no cluster is delivered to macrocell i, the first XOR input is 0, so `dOut[i]` equals its second XOR input. This holds also when its own cluster was routed away.
- R7: Destination bits 8i+3..8i+7 are a one-hot field for offsets -2, -1, 0, +1 and +2, in that order. `dOut[i]` is the OR of every legal cluster delivered to i, XORed with i's second input.
- R8: A destination field with more than one bit set raises `clusterBad[i]`, and that cluster is delivered nowhere.
- R9: A destination outside 0..N-1 raises `clusterBad[i]` and drops the cluster. It does not wrap to the other end of the block.
- R10: `sinkOverload[i]` is 1 exactly when more than four legal clusters are delivered to macrocell i. Their OR still reaches `dOut[i]`.
- R11: An all-zero destination field leaves the cluster unused and does not raise `clusterBad[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ptIn | input | NUM_MC*5 | Product-term values: four cluster terms and one spare term per macrocell |
| cfgIn | input | NUM_MC*8 | Static configuration: one 8-bit word per macrocell |
| dOut | output | NUM_MC | D/T input per macrocell, after the XOR |
| clusterBad | output | NUM_MC | Cluster i has an illegal destination and was dropped |
| sinkOverload | output | NUM_MC | Macrocell i receives more clusters than the join limit |

## Verification
The bench targets the corner cases where a plausible design goes wrong:
- An asynchronous cluster moved to a synchronous neighbour must still drop its upper two terms. A design that sized clusters by the receiving macrocell would let them through.
- Clusters aimed past either end must vanish rather than wrap. A wrapping design would light up the macrocell at the opposite end.
- A multi-destination field must deliver nothing. A permissive design would duplicate the cluster.
- A macrocell that gives its cluster away must still show its spare term, or its polarity, at the XOR.

Directed cases cover each of these. Thousands of random configurations are also compared against an arithmetic model, with destination fields biased towards legal and edge-of-block values.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  // Configuration word layout per macrocell
  localparam int CFG_W     = 8;
  localparam int CFG_ASYNC = 0;
  localparam int CFG_XSRC  = 1;
  localparam int CFG_POL   = 2;
  localparam int DEST_LSB  = 3;
  localparam int REACH     = 2;
  localparam int DEST_W    = 2 * REACH + 1;
  // Widest cluster the strobe struct can carry
  localparam int MAX_TERMS = 4;

  typedef struct packed {
    logic [MAX_TERMS-1:0] termMask;     // cluster terms that count
    logic                 extraJoin;    // spare term rides with the cluster
    logic                 xorFromExtra; // spare term drives XOR input B
    logic                 polarity;     // constant XOR input B
    logic [DEST_W-1:0]    deliver;      // legal one-hot destination, or zero
  } ptc_strobe_t;
endpackage

// File: rtl/ptc_route_ctrl.sv
module ptc_route_ctrl
  import ptc_pkg::*;
#(
  parameter int NUM_MC     = 8,
  parameter int SYNC_SIZE  = 4,
  parameter int ASYNC_SIZE = 2,
  parameter int MAX_JOIN   = 4
) (
  input  logic [NUM_MC*CFG_W-1:0]     cfgIn,
  output ptc_strobe_t [NUM_MC-1:0]    strobe,
  output logic [NUM_MC-1:0]           clusterBad,
  output logic [NUM_MC-1:0]           sinkOverload
);
  localparam logic [MAX_TERMS-1:0] SYNC_MASK  = MAX_TERMS'((1 << SYNC_SIZE) - 1);
  localparam logic [MAX_TERMS-1:0] ASYNC_MASK = MAX_TERMS'((1 << ASYNC_SIZE) - 1);

  // Per-source decode: legality and strobes
  for (genvar c = 0; c < NUM_MC; c++) begin : g_src
    logic [CFG_W-1:0]  word;
    logic [DEST_W-1:0] dest;
    logic [DEST_W-1:0] offEndBits;
    logic              multiDest;
    logic              bad;

    assign word = cfgIn[c*CFG_W +: CFG_W];
    assign dest = word[DEST_LSB +: DEST_W];

    for (genvar k = 0; k < DEST_W; k++) begin : g_off
      localparam int DST = c + k - REACH;
      if (DST < 0 || DST >= NUM_MC) begin : g_out
        assign offEndBits[k] = dest[k];
      end else begin : g_in
        assign offEndBits[k] = 1'b0;
      end
    end

    assign multiDest     = ($countones(dest) > 1);
    assign bad           = multiDest | (|offEndBits);
    assign clusterBad[c] = bad;

    always_comb begin
      strobe[c].termMask     = word[CFG_ASYNC] ? ASYNC_MASK : SYNC_MASK;
      strobe[c].extraJoin    = ~word[CFG_XSRC];
      strobe[c].xorFromExtra = word[CFG_XSRC];
      strobe[c].polarity     = word[CFG_POL];
      strobe[c].deliver      = bad ? '0 : dest;
    end
  end

  // Per-sink join count
  for (genvar i = 0; i < NUM_MC; i++) begin : g_sink
    logic [DEST_W-1:0] hit;
    for (genvar k = 0; k < DEST_W; k++) begin : g_hit
      localparam int SRC = i - k + REACH;
      if (SRC >= 0 && SRC < NUM_MC) begin : g_ok
        assign hit[k] = strobe[SRC].deliver[k];
      end else begin : g_none
        assign hit[k] = 1'b0;
      end
    end
    assign sinkOverload[i] = ($countones(hit) > MAX_JOIN);
  end
endmodule

// File: rtl/ptc_sum_xor.sv
module ptc_sum_xor
  import ptc_pkg::*;
#(
  parameter int NUM_MC    = 8,
  parameter int SYNC_SIZE = 4
) (
  input  logic [NUM_MC*(SYNC_SIZE+1)-1:0] ptIn,
  input  ptc_strobe_t [NUM_MC-1:0]        strobe,
  output logic [NUM_MC-1:0]               dOut
);
  localparam int PT_PER_MC = SYNC_SIZE + 1;

  logic [NUM_MC-1:0] clusterVal;
  logic [NUM_MC-1:0] extraTerm;

  for (genvar c = 0; c < NUM_MC; c++) begin : g_clu
    logic [SYNC_SIZE-1:0] terms;
    assign terms         = ptIn[c*PT_PER_MC +: SYNC_SIZE];
    assign extraTerm[c]  = ptIn[c*PT_PER_MC + SYNC_SIZE];
    assign clusterVal[c] = (|(terms & strobe[c].termMask[SYNC_SIZE-1:0]))
                         | (strobe[c].extraJoin & extraTerm[c]);
  end

  for (genvar i = 0; i < NUM_MC; i++) begin : g_out
    logic [DEST_W-1:0] contrib;
    logic              sumIn;
    logic              xorB;
    for (genvar k = 0; k < DEST_W; k++) begin : g_k
      localparam int SRC = i - k + REACH;
      if (SRC >= 0 && SRC < NUM_MC) begin : g_ok
        assign contrib[k] = strobe[SRC].deliver[k] & clusterVal[SRC];
      end else begin : g_none
        assign contrib[k] = 1'b0;
      end
    end
    assign sumIn   = |contrib;
    assign xorB    = strobe[i].xorFromExtra ? extraTerm[i] : strobe[i].polarity;
    assign dOut[i] = sumIn ^ xorB;
  end
endmodule

// File: rtl/ptc_allocator.sv
module ptc_allocator
  import ptc_pkg::*;
#(
  parameter int NUM_MC     = 8,
  parameter int SYNC_SIZE  = 4,
  parameter int ASYNC_SIZE = 2,
  parameter int MAX_JOIN   = 4
) (
  input  logic [NUM_MC*(SYNC_SIZE+1)-1:0] ptIn,
  input  logic [NUM_MC*CFG_W-1:0]         cfgIn,
  output logic [NUM_MC-1:0]               dOut,
  output logic [NUM_MC-1:0]               clusterBad,
  output logic [NUM_MC-1:0]               sinkOverload
);
  ptc_strobe_t [NUM_MC-1:0] strobe;

  ptc_route_ctrl #(
    .NUM_MC(NUM_MC), .SYNC_SIZE(SYNC_SIZE),
    .ASYNC_SIZE(ASYNC_SIZE), .MAX_JOIN(MAX_JOIN)
  ) u_ctrl (
    .cfgIn(cfgIn), .strobe(strobe),
    .clusterBad(clusterBad), .sinkOverload(sinkOverload)
  );

  ptc_sum_xor #(
    .NUM_MC(NUM_MC), .SYNC_SIZE(SYNC_SIZE)
  ) u_dp (
    .ptIn(ptIn), .strobe(strobe), .dOut(dOut)
  );
endmodule

// File: rtl/ptc_allocator_chk.sv
module ptc_allocator_chk
  import ptc_pkg::*;
#(
  parameter int NUM_MC     = 8,
  parameter int SYNC_SIZE  = 4,
  parameter int ASYNC_SIZE = 2,
  parameter int MAX_JOIN   = 4
) (
  input logic [NUM_MC*(SYNC_SIZE+1)-1:0] ptIn,
  input logic [NUM_MC*CFG_W-1:0]         cfgIn,
  input logic [NUM_MC-1:0]               dOut,
  input logic [NUM_MC-1:0]               clusterBad,
  input logic [NUM_MC-1:0]               sinkOverload
);
  localparam int PPM = SYNC_SIZE + 1;

  always_comb begin
    logic allEmpty;
    logic allHome;
    allEmpty = 1'b1;
    allHome  = 1'b1;
    for (int c = 0; c < NUM_MC; c++) begin
      if (cfgIn[c*CFG_W+DEST_LSB +: DEST_W] != '0) allEmpty = 1'b0;
      if (cfgIn[c*CFG_W+DEST_LSB +: DEST_W] != DEST_W'(1 << REACH)) allHome = 1'b0;
    end
    for (int c = 0; c < NUM_MC; c++) begin
      logic [DEST_W-1:0] d;
      logic              xsrc;
      logic              extra;
      logic              bSide;
      logic              csum;
      int                raw;
      d     = cfgIn[c*CFG_W+DEST_LSB +: DEST_W];
      xsrc  = cfgIn[c*CFG_W+CFG_XSRC];
      extra = ptIn[c*PPM+SYNC_SIZE];
      bSide = xsrc ? extra : cfgIn[c*CFG_W+CFG_POL];
      csum  = 1'b0;
      for (int t = 0; t < SYNC_SIZE; t++)
        if (t < (cfgIn[c*CFG_W+CFG_ASYNC] ? ASYNC_SIZE : SYNC_SIZE))
          csum = csum | ptIn[c*PPM+t];
      csum = csum | (~xsrc & extra);
      raw = 0;
      for (int k = 0; k < DEST_W; k++) begin
        if ((c - k + REACH) >= 0 && (c - k + REACH) < NUM_MC)
          if (cfgIn[(c-k+REACH)*CFG_W+DEST_LSB+k]) raw++;
      end

      AST_MULTI_DEST_FLAG: assert (!($countones(d) > 1) || clusterBad[c]); // R8
      AST_EMPTY_DEST_OK: assert (d != '0 || !clusterBad[c]); // R11
      AST_NO_WRAP_LOW: assert (!(c < REACH && (d & DEST_W'((1 << (REACH - c)) - 1)) != '0) || clusterBad[c]); // R9
      AST_NO_WRAP_HIGH: assert (!(c >= NUM_MC - REACH && (d >> (NUM_MC - c + REACH)) != '0) || clusterBad[c]); // R9
      AST_EMPTY_SINK_XOR_B: assert (!allEmpty || dOut[c] == bSide); // R6
      AST_HOME_SUM: assert (!allHome || dOut[c] == (csum ^ bSide)); // R4
      AST_OVERLOAD_CAUSE: assert (!sinkOverload[c] || raw > MAX_JOIN); // R10
    end
  end
endmodule

bind ptc_allocator ptc_allocator_chk #(
  .NUM_MC(NUM_MC), .SYNC_SIZE(SYNC_SIZE),
  .ASYNC_SIZE(ASYNC_SIZE), .MAX_JOIN(MAX_JOIN)
) u_chk (
  .ptIn(ptIn), .cfgIn(cfgIn), .dOut(dOut),
  .clusterBad(clusterBad), .sinkOverload(sinkOverload)
);

// File: tb/ptc_allocator_tb.sv
module ptc_allocator_tb;
  localparam int NM  = 8;
  localparam int PPM = 5;
  localparam int CW  = 8;
  localparam int PTW = NM * PPM;
  localparam int CFW = NM * CW;
  localparam logic [4:0] D_M2 = 5'b00001, D_M1 = 5'b00010, D_H = 5'b00100,
                         D_P1 = 5'b01000, D_P2 = 5'b10000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [PTW-1:0] ptv;
  logic [CFW-1:0] cfgv;
  logic [NM-1:0]  dOut, clusterBad, sinkOverload;
  int checkCnt = 0;
  int failCnt  = 0;

  ptc_allocator u_dut (
    .ptIn(ptv), .cfgIn(cfgv), .dOut(dOut),
    .clusterBad(clusterBad), .sinkOverload(sinkOverload)
  );

  task automatic setCfg(input int i, input logic as, input logic xs, input logic pol,
                        input logic [4:0] dst);
    cfgv[i*CW +: CW] = {dst, pol, xs, as};
  endtask

  task automatic clearAll();
    ptv  = '0;
    cfgv = '0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkBit(input string tag, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic model(output logic [NM-1:0] ed, output logic [NM-1:0] eb,
                       output logic [NM-1:0] eo);
    logic [NM-1:0] cv;
    for (int s = 0; s < NM; s++) begin
      logic [4:0] ds;
      int n;
      logic off;
      logic v;
      ds = cfgv[s*CW+3 +: 5];
      n = 0; off = 1'b0; v = 1'b0;
      for (int k = 0; k < 5; k++)
        if (ds[k]) begin
          n++;
          if (s + k - 2 < 0 || s + k - 2 >= NM) off = 1'b1;
        end
      eb[s] = (n > 1) || off;
      for (int t = 0; t < (cfgv[s*CW] ? 2 : 4); t++) v = v | ptv[s*PPM+t];
      if (!cfgv[s*CW+1]) v = v | ptv[s*PPM+4];
      cv[s] = v;
    end
    for (int i = 0; i < NM; i++) begin
      logic acc;
      int cnt;
      acc = 1'b0; cnt = 0;
      for (int s = 0; s < NM; s++) begin
        int o;
        o = i - s;
        if (o >= -2 && o <= 2 && !eb[s] && cfgv[s*CW+3+o+2]) begin
          acc = acc | cv[s];
          cnt++;
        end
      end
      ed[i] = acc ^ (cfgv[i*CW+1] ? ptv[i*PPM+4] : cfgv[i*CW+2]);
      eo[i] = cnt > 4;
    end
  endtask

  task automatic chkAll(input string tag);
    logic [NM-1:0] ed, eb, eo;
    model(ed, eb, eo);
    checkCnt++;
    if (dOut !== ed || clusterBad !== eb || sinkOverload !== eo) begin
      failCnt++;
      $display("FAIL %s act d=%h bad=%h ov=%h exp d=%h bad=%h ov=%h",
               tag, dOut, clusterBad, sinkOverload, ed, eb, eo);
    end
  endtask

  function automatic logic [4:0] pickDest(input int r);
    case (r % 8)
      0: return 5'b0;
      1: return D_H;
      2: return D_P1;
      3: return D_P2;
      4: return D_M1;
      5: return D_M2;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    clearAll();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    settle();
    // Idle state: all-zero inputs give all-zero outputs
    chkBit("R6 idle dOut", |dOut, 1'b0);
    chkBit("R11 idle bad", |clusterBad, 1'b0);
    chkBit("R10 idle overload", |sinkOverload, 1'b0);

    // R1: synchronous home cluster, term 2
    clearAll(); setCfg(3, 0, 0, 0, D_H); ptv[3*PPM+2] = 1'b1; settle();
    chkBit("R1 sync term2", dOut[3], 1'b1);
    chkAll("R1 full");

    // R2: async upper terms ignored, lower terms count
    clearAll(); setCfg(3, 1, 0, 0, D_H); ptv[3*PPM+3] = 1'b1; ptv[3*PPM+2] = 1'b1; settle();
    chkBit("R2 async upper ignored", dOut[3], 1'b0);
    ptv[3*PPM+1] = 1'b1; settle();
    chkBit("R2 async lower", dOut[3], 1'b1);

    // R3: async cluster routed to synchronous neighbour keeps size 2
    clearAll(); setCfg(2, 1, 0, 0, D_P1); setCfg(3, 0, 0, 0, D_H);
    ptv[2*PPM+3] = 1'b1; settle();
    chkBit("R3 routed async upper", dOut[3], 1'b0);
    ptv[2*PPM+0] = 1'b1; settle();
    chkBit("R3 routed async lower", dOut[3], 1'b1);

    // R4: extended cluster with polarity, and spare term travelling
    clearAll(); setCfg(4, 0, 0, 0, D_H); ptv[4*PPM+4] = 1'b1; settle();
    chkBit("R4 extended pol0", dOut[4], 1'b1);
    setCfg(4, 0, 0, 1, D_H); settle();
    chkBit("R4 extended pol1", dOut[4], 1'b0);
    setCfg(4, 0, 0, 0, D_P2); settle();
    chkBit("R4 spare travels", dOut[6], 1'b1);
    chkBit("R4 home empty", dOut[4], 1'b0);

    // R5: spare to XOR, polarity ignored
    clearAll(); setCfg(5, 0, 1, 1, D_H); ptv[5*PPM+4] = 1'b1; settle();
    chkBit("R5 spare on xor", dOut[5], 1'b1);
    ptv[5*PPM+0] = 1'b1; settle();
    chkBit("R5 sum xor spare", dOut[5], 1'b0);

    // R6: cluster routed away, spare still at home macrocell
    clearAll(); setCfg(1, 0, 1, 0, D_P1); ptv[1*PPM+0] = 1'b1; ptv[1*PPM+4] = 1'b1; settle();
    chkBit("R6 routed away home", dOut[1], 1'b1);
    chkBit("R6 routed away dest", dOut[2], 1'b1);

    // R7: four clusters gang onto macrocell 2
    clearAll(); setCfg(0, 0, 0, 0, D_P2); setCfg(1, 0, 0, 0, D_P1);
    setCfg(3, 0, 0, 0, D_M1); setCfg(4, 0, 0, 0, D_M2);
    ptv[4*PPM+1] = 1'b1; settle();
    chkBit("R7 gang sum", dOut[2], 1'b1);
    chkBit("R7 no overload at four", sinkOverload[2], 1'b0);
    chkAll("R7 gang full");

    // R8: two destinations
    clearAll(); setCfg(5, 0, 0, 0, D_H | D_P1); ptv[5*PPM+0] = 1'b1; settle();
    chkBit("R8 flag", clusterBad[5], 1'b1);
    chkBit("R8 dropped home", dOut[5], 1'b0);
    chkBit("R8 dropped nbr", dOut[6], 1'b0);

    // R9: off both ends
    clearAll(); setCfg(0, 0, 0, 0, D_M1); setCfg(7, 0, 0, 0, D_P1);
    ptv[0] = 1'b1; ptv[7*PPM] = 1'b1; settle();
    chkBit("R9 low flag", clusterBad[0], 1'b1);
    chkBit("R9 high flag", clusterBad[7], 1'b1);
    chkBit("R9 no wrap", |dOut, 1'b0);

    // R10: five clusters into macrocell 4
    clearAll(); setCfg(2, 0, 0, 0, D_P2); setCfg(3, 0, 0, 0, D_P1); setCfg(4, 0, 0, 0, D_H);
    setCfg(5, 0, 0, 0, D_M1); setCfg(6, 0, 0, 0, D_M2); ptv[6*PPM+3] = 1'b1; settle();
    chkBit("R10 overload", sinkOverload[4], 1'b1);
    chkBit("R10 sum passes", dOut[4], 1'b1);

    // R11: empty destination
    clearAll(); setCfg(6, 0, 0, 1, 5'b0); ptv[6*PPM+0] = 1'b1; settle();
    chkBit("R11 not flagged", clusterBad[6], 1'b0);
    chkBit("R11 polarity only", dOut[6], 1'b1);

    // Sweep: every destination field value on every source
    for (int s = 0; s < NM; s++) begin
      for (int dv = 0; dv < 32; dv++) begin
        ptv = PTW'({$urandom, $urandom});
        cfgv = '0;
        for (int j = 0; j < NM; j++) setCfg(j, 1'($urandom), 1'($urandom), 1'($urandom), 5'b0);
        cfgv[s*CW+3 +: 5] = 5'(dv);
        settle();
        chkAll("R8 R9 R11 dest sweep");
      end
    end

    // Random configurations against the model
    for (int n = 0; n < 3000; n++) begin
      ptv = PTW'({$urandom, $urandom});
      for (int j = 0; j < NM; j++)
        setCfg(j, 1'($urandom), 1'($urandom), 1'($urandom), pickDest(int'($urandom % 64)));
      settle();
      chkAll("R1 R2 R3 R5 R7 R10 random");
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule